// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device out of power-up. It runs a fixed command sequence on a command output and keeps a minimum spacing between commands. It also holds off automatic refresh in the timing word it passes to the memory controller until the sequence has finished. It works from static configuration: a timing word that carries the CAS latency in its low bits, a group configuration word whose bus-width bit selects a 16-bit or 32-bit data bus, and an optional mode-data override.

A single-cycle `start` pulse launches the sequence. The block then presents eleven command strobes in this order:

- a NOP;
- a precharge-all;
- eight auto-refresh commands;
- a mode-register-set.

Every command word carries the mode-register payload in its upper bits. Once the last command has gone out, the block passes the unmodified timing word through, with refresh enabled again, and raises `done`.

The controller is a four-state machine:

- **IDLE** is the state after reset. A `start` pulse moves it to ISSUE with the command index at zero.
- **ISSUE** holds the strobe for one cycle. If the command is the last one, the machine moves to DONE. Otherwise it advances the index and moves to GAP, or straight back to ISSUE when the gap is a single cycle.
- **GAP** waits until the spacing timer expires and then returns to ISSUE.
- **DONE** holds `done` high. A new `start` pulse moves it to ISSUE with the index at zero.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and after its release, `cmd_valid` and `done` are low, and `timing_out` equals `timing_cfg` with the two-bit refresh field at bit `REF_LSB` (default 6) cleared.
- R2: A `start` pulse sampled in IDLE makes `cmd_valid` high in the next cycle, with a NOP command word.
- R3: The strobes of one sequence carry these codes, in order: NOP, precharge-all, exactly `NUM_REFRESH` (default 8) auto-refresh, mode-register-set. That is eleven strobes in total by default.
- R4: `cmd_valid` is a one-cycle strobe. Successive strobes are exactly G cycles apart, where G = max(1, ceil(`MIN_GAP_NS`/`CLK_PERIOD_NS`)). The defaults give G = 10.
- R5: With a zero override, the mode data is derived from the CAS latency and the bus width:
  - The CAS latency is `timing_cfg[2:0]`. A value of 2 selects CL2; any other value selects CL3.
  - The bus width is `group_cfg[9]`: 1 means 32-bit, 0 means 16-bit.
  - The mode data is CL<<5 on a 32-bit bus and CL<<4 on a 16-bit bus. This gives 0x40, 0x60, 0x20 and 0x30.
- R6: A nonzero `mode_override` replaces the computed mode data in every command word.
- R7: The command word is {mode data[7:0], code[1:0]}, with the codes NOP=0, precharge-all=1, auto-refresh=2 and mode-register-set=3. The mode data is present in every command, including the NOP.
- R8: The refresh field of `timing_out` is zero whenever `done` is low. While `done` is high, `timing_out` equals `timing_cfg` unmodified.
- R9: `done` rises in the cycle after the mode-register-set strobe, and no strobe occurs while it is high. It stays high until a `start` pulse is sampled.
- R10: A `start` pulse sampled during ISSUE or GAP has no effect on the command sequence or its timing.
- R11: A `start` pulse sampled in DONE clears `done` and restarts the full sequence, with the NOP strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| timing_cfg | input | TIMING_W (32) | Timing word; bits [2:0] hold the CAS latency, the refresh field is at REF_LSB |
| group_cfg | input | CFG_W (32) | Group configuration; bit WIDTH_BIT (9) selects the 32-bit bus |
| mode_override | input | MODE_W (8) | Mode data override; used when nonzero |
| cmd_valid | output | 1 | One-cycle strobe for each command word |
| cmd_word | output | MODE_W+2 (10) | {mode data, command code} |
| timing_out | output | TIMING_W (32) | Timing word to the controller, refresh gated |
| done | output | 1 | Sequence finished |

## Verification
Counting from the `start` pulse, the n-th strobe (n from 0) is due n·G+1 cycles later, because the state register is the only stage in the path. `done` and the restored timing word are due one cycle after the last strobe. The bench drives `start` on a falling edge and samples every following falling edge. At sample k it expects a strobe exactly when k is a multiple of G and k/G ≤ 10, with the command at index k/G. Two instances run side by side, one with a ten-cycle gap and one with a single-cycle gap, and both are compared against the same arithmetic schedule.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP      = 2'd0,
        CMD_PRECHARGE = 2'd1,
        CMD_REFRESH  = 2'd2,
        CMD_MODESET  = 2'd3
    } cmd_code_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc #(
    parameter int TIMING_W  = 32,
    parameter int CFG_W     = 32,
    parameter int MODE_W    = 8,
    parameter int WIDTH_BIT = 9
) (
    input  logic [TIMING_W-1:0] timing_cfg,
    input  logic [CFG_W-1:0]    group_cfg,
    input  logic [MODE_W-1:0]   mode_override,
    output logic [MODE_W-1:0]   mode_data
);
    logic [2:0]        cas_lat;
    logic              bus_is_32;
    logic [MODE_W-1:0] base_val;
    logic [MODE_W-1:0] calc_val;

    always_comb begin
        cas_lat   = timing_cfg[2:0];
        bus_is_32 = group_cfg[WIDTH_BIT];
        // CL2 payload for latency 2, CL3 payload otherwise
        base_val  = (cas_lat == 3'd2) ? MODE_W'(8'h40) : MODE_W'(8'h60);
        calc_val  = bus_is_32 ? base_val : (base_val >> 1);
        mode_data = (|mode_override) ? mode_override : calc_val;
    end
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int GAP_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);
    generate
        if (GAP_CYC <= 1) begin : g_single
            assign ready = 1'b1;
        end else begin : g_count
            localparam int CNT_W = $clog2(GAP_CYC + 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (arm) begin
                    cnt <= CNT_W'(GAP_CYC - 1);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign ready = (cnt <= CNT_W'(1));
        end
    endgenerate
endmodule

// File: rtl/sdram_cmd_select.sv
module sdram_cmd_select
    import sdram_init_pkg::*;
#(
    parameter int NUM_CMDS = 11,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0] idx,
    output cmd_code_t        code
);
    always_comb begin
        if (idx == '0)                         code = CMD_NOP;
        else if (idx == IDX_W'(1))             code = CMD_PRECHARGE;
        else if (idx == IDX_W'(NUM_CMDS - 1))  code = CMD_MODESET;
        else                                   code = CMD_REFRESH;
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int MIN_GAP_NS    = 80,
    parameter int NUM_REFRESH   = 8,
    parameter int TIMING_W      = 32,
    parameter int CFG_W         = 32,
    parameter int MODE_W        = 8,
    parameter int WIDTH_BIT     = 9,
    parameter int REF_LSB       = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TIMING_W-1:0]  timing_cfg,
    input  logic [CFG_W-1:0]     group_cfg,
    input  logic [MODE_W-1:0]    mode_override,
    output logic                 cmd_valid,
    output logic [MODE_W+1:0]    cmd_word,
    output logic [TIMING_W-1:0]  timing_out,
    output logic                 done
);
    localparam int NUM_CMDS = NUM_REFRESH + 3;
    localparam int IDX_W    = $clog2(NUM_CMDS + 1);
    localparam int GAP_RAW  = (MIN_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam logic [TIMING_W-1:0] REF_MASK = ~(TIMING_W'(3) << REF_LSB);

    seq_state_t        state, state_nx;
    logic [IDX_W-1:0]  idx, idx_nx;
    logic [MODE_W-1:0] mode_data;
    cmd_code_t         code;
    logic              gap_ready;
    logic              gap_arm;

    sdram_mode_calc #(
        .TIMING_W (TIMING_W),
        .CFG_W    (CFG_W),
        .MODE_W   (MODE_W),
        .WIDTH_BIT(WIDTH_BIT)
    ) u_mode (
        .timing_cfg   (timing_cfg),
        .group_cfg    (group_cfg),
        .mode_override(mode_override),
        .mode_data    (mode_data)
    );

    sdram_cmd_select #(
        .NUM_CMDS(NUM_CMDS),
        .IDX_W   (IDX_W)
    ) u_sel (
        .idx (idx),
        .code(code)
    );

    sdram_gap_timer #(
        .GAP_CYC(GAP_CYC)
    ) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (gap_arm),
        .ready(gap_ready)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_nx = ST_ISSUE;
                    idx_nx   = '0;
                end
            end
            ST_ISSUE: begin
                if (idx == IDX_W'(NUM_CMDS - 1)) begin
                    state_nx = ST_DONE;
                end else begin
                    idx_nx   = idx + 1'b1;
                    state_nx = (GAP_CYC <= 1) ? ST_ISSUE : ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_ready) state_nx = ST_ISSUE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // outputs
    always_comb begin
        cmd_valid  = 1'b0;
        gap_arm    = 1'b0;
        done       = 1'b0;
        timing_out = timing_cfg & REF_MASK;
        cmd_word   = {mode_data, code};
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                gap_arm   = 1'b1;
            end
            ST_GAP:   ;
            ST_DONE: begin
                done       = 1'b1;
                timing_out = timing_cfg;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int CLK_PERIOD_NS = 8,
    parameter int MIN_GAP_NS    = 80,
    parameter int TIMING_W      = 32,
    parameter int MODE_W        = 8,
    parameter int REF_LSB       = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [TIMING_W-1:0] timing_cfg,
    input logic                cmd_valid,
    input logic [MODE_W+1:0]   cmd_word,
    input logic [TIMING_W-1:0] timing_out,
    input logic                done
);
    localparam int GAP_RAW = (MIN_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int SW      = $clog2(GAP_CYC + 2);

    logic          seen;
    logic [SW-1:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            seen  <= 1'b0;
            since <= '0;
        end else if (cmd_valid) begin
            seen  <= 1'b1;
            since <= SW'(1);
        end else if (since < SW'(GAP_CYC)) begin
            since <= since + 1'b1;
        end
    end

    assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen) |-> (since >= SW'(GAP_CYC)));

    assert_refresh_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (timing_out[REF_LSB +: 2] == 2'b00));

    assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (timing_out == timing_cfg));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cmd_valid) && ($past(cmd_word[1:0]) == 2'd3)));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .MIN_GAP_NS   (MIN_GAP_NS),
    .TIMING_W     (TIMING_W),
    .MODE_W       (MODE_W),
    .REF_LSB      (REF_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .timing_cfg(timing_cfg),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .timing_out(timing_out),
    .done      (done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
    localparam int G0 = 10;   // 80 ns at 8 ns
    localparam int G1 = 1;    // 80 ns at 100 ns
    localparam int NCMD = 11;
    localparam int NSAMP = (NCMD - 1) * G0 + 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] timing_cfg = 32'hA5A5_00C2;
    logic [31:0] group_cfg  = 32'h0000_0200;
    logic [7:0]  mode_override = 8'h00;
    logic        v0, v1, d0, d1;
    logic [9:0]  w0, w1;
    logic [31:0] t0, t1;
    int          checks = 0;
    int          fails  = 0;
    bit          first_run = 1'b1;

    always #4 clk = ~clk;

    sdram_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .timing_cfg(timing_cfg),
        .group_cfg(group_cfg), .mode_override(mode_override),
        .cmd_valid(v0), .cmd_word(w0), .timing_out(t0), .done(d0));

    sdram_init_seq #(.CLK_PERIOD_NS(100)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .timing_cfg(timing_cfg),
        .group_cfg(group_cfg), .mode_override(mode_override),
        .cmd_valid(v1), .cmd_word(w1), .timing_out(t1), .done(d1));

    task automatic chk(input bit ok, input string req, input int inst,
                       input int k, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s inst%0d k=%0d actual=%h expected=%h", req, inst, k, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mode();
        int cl;
        if (mode_override != 8'h00) return mode_override;
        cl = (timing_cfg[2:0] == 3'd2) ? 2 : 3;
        return 8'(cl << (group_cfg[9] ? 5 : 4));
    endfunction

    function automatic logic [1:0] exp_code(input int n);
        if (n == 0) return 2'd0;
        if (n == 1) return 2'd1;
        if (n == NCMD - 1) return 2'd3;
        return 2'd2;
    endfunction

    task automatic check_inst(input int inst, input int g, input int k, input bit mid,
                              input logic v, input logic [9:0] w,
                              input logic [31:0] t, input logic d);
        bit    issue;
        int    n;
        bit    fin;
        string rq;
        issue = (k % g == 0) && (k / g <= NCMD - 1);
        n     = k / g;
        fin   = (k >= (NCMD - 1) * g + 1);
        if (k == 0) rq = first_run ? "R2" : "R11";
        else if (mid && k > 5) rq = "R10";
        else rq = "R4";
        chk(v == issue, rq, inst, k, 32'(v), 32'(issue));
        if (issue && v) begin
            // R3 order, R5 computed mode, R6 override, R7 layout
            rq = (mode_override != 0) ? "R6" : ((n == NCMD - 1) ? "R5" : "R3");
            chk(w == {exp_mode(), exp_code(n)}, rq, inst, k, 32'(w), 32'({exp_mode(), exp_code(n)}));
        end
        chk(d == fin, "R9", inst, k, 32'(d), 32'(fin));
        chk(t == (fin ? timing_cfg : (timing_cfg & ~32'h0000_00C0)), "R8", inst, k, t,
            fin ? timing_cfg : (timing_cfg & ~32'h0000_00C0));
    endtask

    task automatic run_seq(input bit mid);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < NSAMP; k++) begin
            if (k != 0) @(negedge clk);
            check_inst(0, G0, k, mid, v0, w0, t0, d0);
            check_inst(1, G1, k, mid, v1, w1, t1, d1);
            if (mid && k == 5) start = 1'b1;
            if (mid && k == 6) start = 1'b0;
        end
        first_run = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(v0 == 1'b0 && v1 == 1'b0, "R1", 0, 0, 32'({v0, v1}), 32'h0);
        chk(d0 == 1'b0 && d1 == 1'b0, "R1", 0, 0, 32'({d0, d1}), 32'h0);
        chk(t0 == (timing_cfg & ~32'h0000_00C0), "R1", 0, 0, t0, timing_cfg & ~32'h0000_00C0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(v0 == 1'b0 && d0 == 1'b0, "R1", 0, 1, 32'({v0, d0}), 32'h0);
        for (int cl = 0; cl < 8; cl++) begin
            for (int wd = 0; wd < 2; wd++) begin
                timing_cfg = 32'hA5A5_00C0 | 32'(cl);
                group_cfg  = wd ? 32'h0000_0200 : 32'h0000_0000;
                run_seq((cl == 3) && (wd == 1));
            end
        end
        mode_override = 8'h15;
        run_seq(1'b0);
        mode_override = 8'hFF;
        group_cfg = 32'h0000_0000;
        run_seq(1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule